// File: doc/BRIEF.md
# Multi-Mode External Parallel Bus Master

This block is a master for an external parallel bus with 8-bit or 16-bit data. An internal client hands it one command at a time on a valid/ready port. The command gives the direction, the chip-select number, the address and the write data. The block runs the matching pin-level cycle and returns one response per command, which carries the read data or an error flag.

A 2-bit mode input selects one of four bus styles:
- **Multiplexed address/data (0):** the low address bits go out on the data pins during an address phase, marked by a latch strobe.
- **Separate address and data (1):** the address stays on its own pins for the whole access.
- **Continuous read (2):** output enable stays asserted and only the address moves.
- **FIFO (3):** no address is driven, and the bus can optionally wait on external full and empty flags.

Bus timing comes from a per-access rate divider. A second divider is available for chip select 1. Separate read and write wait-state counts stretch the data phase.

Tristate control appears as a data output-enable signal. The address-phase and data-phase cycles are counted in "ticks". One tick lasts rate+1 clocks.

Top module: `hbus_ctrl`

## Requirements
- R1: During and after synchronous reset, the outputs are idle until the first command: `cmd_ready`=1, `rsp_valid`=0, `bus_rd_n`=`bus_wr_n`=`bus_cs0_n`=`bus_cs1_n`=`bus_oe_n`=1, `bus_ale`=0, `bus_doe`=0.
- R2: In mode 0, each access begins with an address phase one tick long.
  - During that phase, the low data-width bits of the address are driven on `bus_dout` with `bus_doe`=1.
  - When `cfg_cs_style` is 0 or 3, `bus_ale` is 1 for exactly that tick.
  - The data phase follows at once.
- R3: In modes 0 and 1, `bus_addr` carries the full 20-bit command address through the address and data phases. In mode 1, `bus_ale` never rises.
- R4: The chip-select style works as follows. In every style, the selected line is low for the entire address and data phases, and the two lines are never low together.

  | `cfg_cs_style` | `bus_ale` | Chip-select lines |
  |---|---|---|
  | 0 | used | none |
  | 1 | never | `bus_cs0_n` only |
  | 3 | used | `bus_cs0_n` when `cmd_cs`=0, `bus_cs1_n` when `cmd_cs`=1 |

- R5: One tick is rate+1 clocks. From the accepting clock edge, the response appears after (address phase ? rate+1 : 0) + data phase length + 1 clocks. The data phase lasts (1+wait)·(rate+1) clocks.
- R6: With `cfg_split_rate`=1, chip-select-1 commands use `cfg_rate1`. All other commands use `cfg_rate0`.
- R7: Reads stretch the data phase by `cfg_rd_wait` ticks, and writes by `cfg_wr_wait` ticks. The `bus_rd_n` or `bus_wr_n` low pulse covers the data phase exactly.
- R8: In mode 2:
  - `bus_oe_n` is held low and `bus_rd_n`/`bus_wr_n` stay high.
  - Each read drives its address for one data phase and returns the data present at the end of that phase.
  - Consecutive commands step the address (for example 0x100, then 0x101).
- R9: In mode 2, a write command gets a response one clock after acceptance with `rsp_err`=1, and no bus activity occurs.
- R10: In mode 3, `bus_addr` stays 0 and `bus_ale` stays 0. With `cfg_flag_gate`=1, a read waits with no strobe while `fifo_empty`=1, and a write waits while `fifo_full`=1.
- R11: With `cfg_wide`=0, only bits 7:0 of `bus_dout` are driven (bits 15:8 are 0), and `rsp_rdata` bits 15:8 read 0.
- R12: A write drives `cmd_wdata` on `bus_dout` with `bus_doe`=1 while `bus_wr_n` is low. `bus_doe` is never 1 while `bus_rd_n` is low. A read returns the `bus_din` value sampled at the end of the data phase. `rsp_valid` is a one-clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 multiplexed, 1 separate, 2 continuous read, 3 FIFO |
| cfg_cs_style | input | 2 | 0 latch strobe only, 1 single chip select, 3 strobe plus two chip selects |
| cfg_wide | input | 1 | 1 selects 16-bit data, 0 selects 8-bit data |
| cfg_split_rate | input | 1 | 1 gives chip select 1 its own rate |
| cfg_rate0 | input | 4 | Rate divider count for chip select 0 (and for both when not split) |
| cfg_rate1 | input | 4 | Rate divider count for chip select 1 |
| cfg_rd_wait | input | 4 | Read wait-state ticks |
| cfg_wr_wait | input | 4 | Write wait-state ticks |
| cfg_flag_gate | input | 1 | Honour the FIFO flags in mode 3 |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block is idle and takes the command |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_cs | input | 1 | Chip-select number |
| cmd_addr | input | 20 | Command address |
| cmd_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Command was rejected |
| rsp_rdata | output | 16 | Read data |
| bus_addr | output | 20 | Address pins |
| bus_dout | output | 16 | Data pins, outgoing value |
| bus_doe | output | 1 | Data pin output enable |
| bus_din | input | 16 | Data pins, incoming value |
| bus_ale | output | 1 | Address latch strobe |
| bus_cs0_n | output | 1 | Chip select 0, active low |
| bus_cs1_n | output | 1 | Chip select 1, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_oe_n | output | 1 | Continuous-read output enable, active low |
| fifo_full | input | 1 | External FIFO full flag |
| fifo_empty | input | 1 | External FIFO empty flag |

## Verification
The assertions assume the following about the inputs:
- All configuration inputs change only while the block is idle, with no command in flight.
- The chip-select style is never 2.
- `cmd_valid` is raised only when `cmd_ready` is high.
- The FIFO flags are not expected to be honoured outside mode 3.

The stimulus respects these by reprogramming the configuration only after a response has been seen. It issues commands one at a time and draws the styles from 0, 1 and 3 only. It moves the flags only during the gated FIFO cases, and it runs the continuous-read cases last, because the address held in mode 2 would otherwise appear at the start of a later mode.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_WAITF = 3'd2,
    PH_DATA  = 3'd3,
    PH_RESP  = 3'd4
  } phase_t;

  localparam logic [1:0] MODE_MUX  = 2'd0;
  localparam logic [1:0] MODE_SEP  = 2'd1;
  localparam logic [1:0] MODE_CONT = 2'd2;
  localparam logic [1:0] MODE_FIFO = 2'd3;

  localparam logic [1:0] CS_ALE  = 2'd0;
  localparam logic [1:0] CS_ONE  = 2'd1;
  localparam logic [1:0] CS_DUAL = 2'd3;
endpackage

// File: rtl/hbus_tick.sv
module hbus_tick #(
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [DIVW-1:0] limit,
  output logic            tick
);
  logic [DIVW-1:0] cnt_q;

  assign tick = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // counter never runs past the programmed rate
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= limit);
endmodule

// File: rtl/hbus_seq.sv
module hbus_seq import hbus_pkg::*; #(
  parameter int AW   = 20,
  parameter int DW   = 16,
  parameter int DIVW = 4,
  parameter int WSW  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      cfg_mode,
  input  logic            cfg_split_rate,
  input  logic [DIVW-1:0] cfg_rate0,
  input  logic [DIVW-1:0] cfg_rate1,
  input  logic [WSW-1:0]  cfg_rd_wait,
  input  logic [WSW-1:0]  cfg_wr_wait,
  input  logic            cfg_flag_gate,
  input  logic [DW-1:0]   lane_mask,
  input  logic            fifo_full,
  input  logic            fifo_empty,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic            cmd_write,
  input  logic            cmd_cs,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [DW-1:0]   cmd_wdata,
  input  logic [DW-1:0]   bus_din,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [DW-1:0]   rsp_rdata,
  output phase_t          nxt_phase,
  output logic            nxt_wr,
  output logic            nxt_cs,
  output logic [AW-1:0]   nxt_addr,
  output logic [DW-1:0]   nxt_wdata
);
  phase_t          ph_q, ph_d;
  logic            wr_q, cs_q, err_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q, rdata_q;
  logic [WSW-1:0]  wcnt_q, ws;
  logic [DIVW-1:0] limit;
  logic            accept, blk_now, blk_held, tick, clr, last_beat, fifo_gated;

  assign accept     = (ph_q == PH_IDLE) && cmd_valid;
  assign fifo_gated = (cfg_mode == MODE_FIFO) && cfg_flag_gate;
  assign blk_now    = fifo_gated && (cmd_write ? fifo_full : fifo_empty);
  assign blk_held   = fifo_gated && (wr_q ? fifo_full : fifo_empty);
  assign ws         = wr_q ? cfg_wr_wait : cfg_rd_wait;
  assign limit      = (cfg_split_rate && cs_q) ? cfg_rate1 : cfg_rate0;
  assign last_beat  = (ph_q == PH_DATA) && tick && (wcnt_q == ws);

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE: if (cmd_valid) begin
        if (cmd_write && cfg_mode == MODE_CONT)                   ph_d = PH_RESP;
        else if (cfg_mode == MODE_MUX || cfg_mode == MODE_SEP)    ph_d = PH_ADDR;
        else if (blk_now)                                         ph_d = PH_WAITF;
        else                                                      ph_d = PH_DATA;
      end
      PH_WAITF: if (!blk_held) ph_d = PH_DATA;
      PH_ADDR:  if (tick)      ph_d = PH_DATA;
      PH_DATA:  if (last_beat) ph_d = PH_RESP;
      default:                 ph_d = PH_IDLE;
    endcase
  end

  assign clr = (ph_d != ph_q) || (ph_q != PH_ADDR && ph_q != PH_DATA);

  hbus_tick #(.DIVW(DIVW)) tick_i (
    .clk(clk), .rst(rst), .clr(clr), .limit(limit), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      wr_q    <= 1'b0;
      cs_q    <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      wcnt_q  <= '0;
    end else begin
      ph_q <= ph_d;
      if (accept) begin
        wr_q    <= cmd_write;
        cs_q    <= cmd_cs;
        addr_q  <= cmd_addr;
        wdata_q <= cmd_wdata;
        err_q   <= cmd_write && (cfg_mode == MODE_CONT);
        rdata_q <= '0;
      end
      if (last_beat && !wr_q) rdata_q <= bus_din & lane_mask;
      if (ph_q != PH_DATA)    wcnt_q  <= '0;
      else if (tick)          wcnt_q  <= wcnt_q + 1'b1;
    end
  end

  assign nxt_phase = ph_d;
  assign nxt_wr    = accept ? cmd_write : wr_q;
  assign nxt_cs    = accept ? cmd_cs    : cs_q;
  assign nxt_addr  = accept ? cmd_addr  : addr_q;
  assign nxt_wdata = accept ? cmd_wdata : wdata_q;

  assign cmd_ready = (ph_q == PH_IDLE);
  assign rsp_valid = (ph_q == PH_RESP);
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;

  assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_err_cont_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (cfg_mode == MODE_CONT));
endmodule

// File: rtl/hbus_pins.sv
module hbus_pins import hbus_pkg::*; #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cfg_mode,
  input  logic [1:0]    cfg_cs_style,
  input  logic [DW-1:0] lane_mask,
  input  phase_t        nxt_phase,
  input  logic          nxt_wr,
  input  logic          nxt_cs,
  input  logic [AW-1:0] nxt_addr,
  input  logic [DW-1:0] nxt_wdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  output logic          bus_ale,
  output logic          bus_cs0_n,
  output logic          bus_cs1_n,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic          bus_oe_n
);
  logic          in_addr, in_data, busy, use_ale, dual, cs_on, strb, drv_a, drv_w;
  logic          ale_d, cs0_d, cs1_d, rd_d, wr_d, doe_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] dout_d;

  always_comb begin
    in_addr = (nxt_phase == PH_ADDR);
    in_data = (nxt_phase == PH_DATA);
    busy    = in_addr || in_data;
    use_ale = (cfg_cs_style == CS_ALE) || (cfg_cs_style == CS_DUAL);
    dual    = (cfg_cs_style == CS_DUAL);
    cs_on   = busy && (cfg_cs_style != CS_ALE);
    ale_d   = in_addr && (cfg_mode == MODE_MUX) && use_ale;
    cs0_d   = !(cs_on && !(dual && nxt_cs));
    cs1_d   = !(cs_on && dual && nxt_cs);
    strb    = in_data && (cfg_mode != MODE_CONT);
    rd_d    = !(strb && !nxt_wr);
    wr_d    = !(strb && nxt_wr);
    drv_a   = in_addr && (cfg_mode == MODE_MUX);
    drv_w   = in_data && nxt_wr;
    doe_d   = drv_a || drv_w;
    if (drv_a)      dout_d = nxt_addr[DW-1:0] & lane_mask;
    else if (drv_w) dout_d = nxt_wdata & lane_mask;
    else            dout_d = '0;
    if (cfg_mode == MODE_FIFO)      addr_d = '0;
    else if (busy)                  addr_d = nxt_addr;
    else if (cfg_mode == MODE_CONT) addr_d = bus_addr;
    else                            addr_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr  <= '0;
      bus_dout  <= '0;
      bus_doe   <= 1'b0;
      bus_ale   <= 1'b0;
      bus_cs0_n <= 1'b1;
      bus_cs1_n <= 1'b1;
      bus_rd_n  <= 1'b1;
      bus_wr_n  <= 1'b1;
      bus_oe_n  <= 1'b1;
    end else begin
      bus_addr  <= addr_d;
      bus_dout  <= dout_d;
      bus_doe   <= doe_d;
      bus_ale   <= ale_d;
      bus_cs0_n <= cs0_d;
      bus_cs1_n <= cs1_d;
      bus_rd_n  <= rd_d;
      bus_wr_n  <= wr_d;
      bus_oe_n  <= (cfg_mode != MODE_CONT);
    end
  end

  assert_ale_then_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ale) |-> (!bus_rd_n || !bus_wr_n));

  assert_cont_nostrobe_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == MODE_CONT) |-> (bus_rd_n && bus_wr_n));

  assert_fifo_noaddr_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == MODE_FIFO && $past(cfg_mode) == MODE_FIFO) |-> (bus_addr == '0 && !bus_ale));

  assert_no_drive_on_read_R12: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> bus_rd_n);
endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl import hbus_pkg::*; #(
  parameter int AW   = 20,
  parameter int DW   = 16,
  parameter int DIVW = 4,
  parameter int WSW  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      cfg_mode,
  input  logic [1:0]      cfg_cs_style,
  input  logic            cfg_wide,
  input  logic            cfg_split_rate,
  input  logic [DIVW-1:0] cfg_rate0,
  input  logic [DIVW-1:0] cfg_rate1,
  input  logic [WSW-1:0]  cfg_rd_wait,
  input  logic [WSW-1:0]  cfg_wr_wait,
  input  logic            cfg_flag_gate,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic            cmd_write,
  input  logic            cmd_cs,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [DW-1:0]   cmd_wdata,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [DW-1:0]   rsp_rdata,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_dout,
  output logic            bus_doe,
  input  logic [DW-1:0]   bus_din,
  output logic            bus_ale,
  output logic            bus_cs0_n,
  output logic            bus_cs1_n,
  output logic            bus_rd_n,
  output logic            bus_wr_n,
  output logic            bus_oe_n,
  input  logic            fifo_full,
  input  logic            fifo_empty
);
  localparam int LANES = DW / 8;

  logic [DW-1:0] lane_mask;
  phase_t        nxt_phase;
  logic          nxt_wr, nxt_cs;
  logic [AW-1:0] nxt_addr;
  logic [DW-1:0] nxt_wdata;

  // byte lane 0 is always live; upper lanes only in wide mode
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign lane_mask[7:0] = 8'hFF;
    end else begin : g_up
      assign lane_mask[g*8 +: 8] = {8{cfg_wide}};
    end
  end

  hbus_seq #(.AW(AW), .DW(DW), .DIVW(DIVW), .WSW(WSW)) seq_i (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_split_rate(cfg_split_rate),
    .cfg_rate0(cfg_rate0), .cfg_rate1(cfg_rate1), .cfg_rd_wait(cfg_rd_wait),
    .cfg_wr_wait(cfg_wr_wait), .cfg_flag_gate(cfg_flag_gate), .lane_mask(lane_mask),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_write(cmd_write), .cmd_cs(cmd_cs),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .bus_din(bus_din),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .nxt_phase(nxt_phase), .nxt_wr(nxt_wr), .nxt_cs(nxt_cs),
    .nxt_addr(nxt_addr), .nxt_wdata(nxt_wdata)
  );

  hbus_pins #(.AW(AW), .DW(DW)) pins_i (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_cs_style(cfg_cs_style),
    .lane_mask(lane_mask), .nxt_phase(nxt_phase), .nxt_wr(nxt_wr),
    .nxt_cs(nxt_cs), .nxt_addr(nxt_addr), .nxt_wdata(nxt_wdata),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_ale(bus_ale), .bus_cs0_n(bus_cs0_n), .bus_cs1_n(bus_cs1_n),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_oe_n(bus_oe_n)
  );

  assert_cs_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(!bus_cs0_n && !bus_cs1_n));

  assert_fifo_gate_R10: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_rd_n) && cfg_mode == MODE_FIFO && cfg_flag_gate) |-> !$past(fifo_empty));
endmodule

// File: tb/hbus_ctrl_tb_top.sv
module hbus_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20, DW = 16, DIVW = 4, WSW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] cfg_mode = 2'd0, cfg_cs_style = 2'd0;
  logic cfg_wide = 1'b1, cfg_split_rate = 1'b0, cfg_flag_gate = 1'b0;
  logic [DIVW-1:0] cfg_rate0 = 4'd1, cfg_rate1 = 4'd1;
  logic [WSW-1:0] cfg_rd_wait = '0, cfg_wr_wait = '0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, cmd_cs = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata, bus_dout, bus_din;
  logic [AW-1:0] bus_addr;
  logic bus_doe, bus_ale, bus_cs0_n, bus_cs1_n, bus_rd_n, bus_wr_n, bus_oe_n;
  logic fifo_full = 1'b0, fifo_empty = 1'b0;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbus_ctrl #(.AW(AW), .DW(DW), .DIVW(DIVW), .WSW(WSW)) dut_i (.*);

  function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
    return a[15:0] ^ 16'hA5C3 ^ {4{a[19:16]}};
  endfunction
  function automatic logic [DW-1:0] fifo_pat(input int i);
    return 16'h3C00 ^ 16'(i * 37);
  endfunction
  function automatic logic [DW-1:0] lanes(input logic [DW-1:0] v, input logic w);
    return w ? v : {8'h00, v[7:0]};
  endfunction

  // bus-side monitor, sampled on falling edges
  int rd_run = 0, wr_run = 0, ale_run = 0, cs0_run = 0, cs1_run = 0;
  int rd_pulses = 0, wr_pulses = 0, ale_pulses = 0, cs0_pulses = 0, cs1_pulses = 0;
  int last_rd = 0, last_wr = 0, last_ale = 0, last_cs0 = 0, last_cs1 = 0;
  int fifo_idx = 0;
  logic [DW-1:0] cap_wd = '0, adr_lat = '0;
  logic [AW-1:0] cap_wa = '0;
  logic cap_doe = 1'b0, addr_nz = 1'b0;

  assign bus_din = (cfg_mode == 2'd3) ? fifo_pat(fifo_idx) : mem_f(bus_addr);

  always @(negedge clk) if (!rst) begin
    if (!bus_rd_n) rd_run++;
    else if (rd_run != 0) begin last_rd = rd_run; rd_run = 0; rd_pulses++; if (cfg_mode == 2'd3) fifo_idx++; end
    if (!bus_wr_n) begin wr_run++; cap_wd = bus_dout; cap_wa = bus_addr; cap_doe = bus_doe; end
    else if (wr_run != 0) begin last_wr = wr_run; wr_run = 0; wr_pulses++; end
    if (bus_ale) ale_run++;
    else if (ale_run != 0) begin last_ale = ale_run; ale_run = 0; ale_pulses++; end
    if (!bus_cs0_n) cs0_run++;
    else if (cs0_run != 0) begin last_cs0 = cs0_run; cs0_run = 0; cs0_pulses++; end
    if (!bus_cs1_n) cs1_run++;
    else if (cs1_run != 0) begin last_cs1 = cs1_run; cs1_run = 0; cs1_pulses++; end
    if (bus_doe && bus_rd_n && bus_wr_n) adr_lat = bus_dout;
    if (bus_addr != '0) addr_nz = 1'b1;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic w, input logic c, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] rd,
                        output logic er, output int lat);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w; cmd_cs = c; cmd_addr = a; cmd_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    rd = rsp_rdata; er = rsp_err;
    #(CLK_PERIOD/4);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog actual=timeout expected=done");
    summary();
  end

  logic [DW-1:0] rd;
  logic er;
  int lat;

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 cmd_ready", cmd_ready, 1); chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 rd_n", bus_rd_n, 1); chk("R1 wr_n", bus_wr_n, 1);
    chk("R1 cs0_n", bus_cs0_n, 1); chk("R1 cs1_n", bus_cs1_n, 1);
    chk("R1 ale", bus_ale, 0); chk("R1 doe", bus_doe, 0); chk("R1 oe_n", bus_oe_n, 1);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 idle oe_n", bus_oe_n, 1);

    // random sweep over modes 0, 1, 3
    for (int it = 0; it < 90; it++) begin
      logic [1:0] md, cst;
      logic w, c;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int n, ws, tl, dl, exl, p_rd, p_wr, p_ale, p_c0, p_c1, fi;
      bit has_a, exp_ale;
      @(negedge clk);
      case ($urandom % 3) 0: md = 2'd0; 1: md = 2'd1; default: md = 2'd3; endcase
      case ($urandom % 3) 0: cst = 2'd0; 1: cst = 2'd1; default: cst = 2'd3; endcase
      cfg_mode = md; cfg_cs_style = cst; cfg_wide = 1'($urandom);
      cfg_split_rate = 1'($urandom); cfg_rate0 = 4'($urandom % 4); cfg_rate1 = 4'($urandom % 4);
      cfg_rd_wait = 4'($urandom % 4); cfg_wr_wait = 4'($urandom % 4); cfg_flag_gate = 1'b0;
      w = 1'($urandom); c = 1'($urandom); a = AW'($urandom); d = DW'($urandom);
      if (it == 0) begin md = 2'd1; cfg_mode = md; a = 20'hFFFFF; w = 1'b0; end
      @(negedge clk);
      p_rd = rd_pulses; p_wr = wr_pulses; p_ale = ale_pulses; p_c0 = cs0_pulses;
      p_c1 = cs1_pulses; fi = fifo_idx; addr_nz = 1'b0; adr_lat = '0;
      do_cmd(w, c, a, d, rd, er, lat);
      n = (cfg_split_rate && c) ? int'(cfg_rate1) : int'(cfg_rate0);
      tl = n + 1;
      ws = w ? int'(cfg_wr_wait) : int'(cfg_rd_wait);
      has_a = (md <= 2'd1);
      dl = (1 + ws) * tl;
      exl = (has_a ? tl : 0) + dl + 1;
      chk($sformatf("R5 R6 latency it%0d", it), lat, exl);
      chk("R12 no error", er, 0);
      if (w) begin
        chk("R7 wr strobe length", last_wr, dl);
        chk("R12 wr pulses", wr_pulses - p_wr, 1);
        chk("R12 R11 write data", cap_wd, lanes(d, cfg_wide));
        chk("R12 write doe", cap_doe, 1);
        chk("R3 R10 write address", cap_wa, (md == 2'd3) ? '0 : a);
      end else begin
        chk("R7 rd strobe length", last_rd, dl);
        chk("R12 rd pulses", rd_pulses - p_rd, 1);
        chk("R12 R11 read data", rd, lanes((md == 2'd3) ? fifo_pat(fi) : mem_f(a), cfg_wide));
      end
      exp_ale = (md == 2'd0) && (cst != 2'd1);
      chk("R2 R3 ale pulses", ale_pulses - p_ale, exp_ale ? 1 : 0);
      if (exp_ale) chk("R2 ale length", last_ale, tl);
      if (md == 2'd0) chk("R2 muxed address on data pins", adr_lat, lanes(a[DW-1:0], cfg_wide));
      if (md == 2'd3) chk("R10 fifo address stays 0", addr_nz, 0);
      if (cst == 2'd0) begin
        chk("R4 no cs0", cs0_pulses - p_c0, 0); chk("R4 no cs1", cs1_pulses - p_c1, 0);
      end else if (cst == 2'd1 || !c) begin
        chk("R4 cs0 pulse", cs0_pulses - p_c0, 1); chk("R4 cs0 length", last_cs0, exl - 1);
        chk("R4 cs1 idle", cs1_pulses - p_c1, 0);
      end else begin
        chk("R4 cs1 pulse", cs1_pulses - p_c1, 1); chk("R4 cs1 length", last_cs1, exl - 1);
        chk("R4 cs0 idle", cs0_pulses - p_c0, 0);
      end
    end

    // R10 flag-gated FIFO read and write
    @(negedge clk);
    cfg_mode = 2'd3; cfg_cs_style = 2'd1; cfg_wide = 1'b1; cfg_flag_gate = 1'b1;
    cfg_rate0 = 4'd1; cfg_rd_wait = 4'd1; cfg_wr_wait = 4'd0; cfg_split_rate = 1'b0;
    fifo_empty = 1'b1;
    begin
      int p, fi;
      p = rd_pulses; fi = fifo_idx;
      fork
        do_cmd(1'b0, 1'b0, 20'h0, 16'h0, rd, er, lat);
        begin
          repeat (12) @(negedge clk);
          chk("R10 read held while empty", rd_pulses - p + (bus_rd_n ? 0 : 1), 0);
          fifo_empty = 1'b0;
        end
      join
      chk("R10 gated read data", rd, fifo_pat(fi));
      chk("R10 gated read pulses", rd_pulses - p, 1);
      @(negedge clk);
      fifo_full = 1'b1;
      p = wr_pulses;
      fork
        do_cmd(1'b1, 1'b0, 20'h0, 16'hBEEF, rd, er, lat);
        begin
          repeat (12) @(negedge clk);
          chk("R10 write held while full", wr_pulses - p + (bus_wr_n ? 0 : 1), 0);
          fifo_full = 1'b0;
        end
      join
      chk("R10 gated write pulses", wr_pulses - p, 1);
      chk("R10 gated write data", cap_wd, 16'hBEEF);
    end

    // R8 R9 continuous read, run last
    @(negedge clk);
    cfg_mode = 2'd2; cfg_flag_gate = 1'b0; cfg_rate0 = 4'd1; cfg_rd_wait = 4'd2; cfg_wide = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 oe_n held low", bus_oe_n, 0);
    for (int k = 0; k < 4; k++) begin
      int p;
      p = rd_pulses;
      do_cmd(1'b0, 1'b0, 20'h00100 + 20'(k), 16'h0, rd, er, lat);
      chk($sformatf("R8 cont read data %0d", k), rd, mem_f(20'h00100 + 20'(k)));
      chk("R8 cont latency", lat, 3 * 2 + 1);
      chk("R8 no rd strobe", rd_pulses - p, 0);
      chk("R8 oe_n still low", bus_oe_n, 0);
    end
    begin
      int p;
      p = wr_pulses;
      do_cmd(1'b1, 1'b0, 20'h00104, 16'h1234, rd, er, lat);
      chk("R9 write rejected", er, 1);
      chk("R9 reject latency", lat, 1);
      chk("R9 no write strobe", wr_pulses - p, 0);
    end
    cfg_wide = 1'b0;
    @(negedge clk);
    do_cmd(1'b0, 1'b0, 20'h0ABCD, 16'h0, rd, er, lat);
    chk("R11 R8 narrow cont read", rd, {8'h00, mem_f(20'h0ABCD)[7:0]});
    summary();
  end
endmodule